// File: doc/BRIEF.md
# Interrupt Context Push Sequencer

When an interrupt is taken, this block writes the processor's 16-bit flag register and its 20-bit program counter onto a stack in memory. It picks which stack pointer to use, captures the pointer and the context in the acceptance cycle, and emits a short burst of writes on a 16-bit memory write channel that has per-byte enables. Once the burst is finished it reports the stack pointer's new value to the core.

The write channel uses a valid/ready handshake. `wr_valid_o` is raised with the address, data and enables. It stays high, with all three unchanged, until a cycle in which `wr_ready_i` is also high. That cycle completes the write, and the next write, if there is one, is presented in the following cycle. Memory can therefore stall any write for any number of cycles. Control inputs (`accept_i`, the interrupt source information, the pointers and the context) have no handshake. They are sampled only in the acceptance cycle.

The burst depends on the parity of the chosen pointer. An even pointer gives two aligned 16-bit writes, and an odd pointer gives four single-byte writes. In both cases the same four bytes end up below the pointer.

Top module: `intr_ctx_push`

## Requirements
- R1: The user stack pointer `usp_i` is used only when `swi_i` is 1, `swi_num_i` lies between 32 and 63 inclusive, and `uflag_i` is 1. In every other case the interrupt stack pointer `isp_i` is used. `sp_user_o` reports the choice (1 = user), and the value is valid together with `done_o`.
- R2: If the chosen pointer SP is even, exactly two writes are issued, each with `wr_be_o` = 2'b11. The first goes to address SP-2 with data {flag[15:12], pc[19:16], flag[7:0]}. The second goes to address SP-4 with data pc[15:0].
- R3: If SP is odd, exactly four byte writes are issued, to addresses SP-1, SP-2, SP-3 and SP-4 in that order.
- R4: The bytes stored from address SP-4 upward are pc[7:0], pc[15:8], flag[7:0], and then a combined byte. The combined byte has flag[15:12] in bits 7:4 and pc[19:16] in bits 3:0.
- R5: A 16-bit write always uses an even address, with the lower address in data bits 7:0. A byte write at an even address uses `wr_be_o` = 2'b01 and carries the byte on bits 7:0. A byte write at an odd address uses 2'b10 and carries the byte on bits 15:8. The unused lane is driven to zero.
- R6: While `wr_valid_o` is 1 and `wr_ready_i` is 0, on the next cycle `wr_valid_o` stays 1 and the address, data and byte enables are unchanged.
- R7: `done_o` is 1 for exactly one cycle. That cycle is the one directly after the handshake of the last write, and `wr_valid_o` is 0 during it.
- R8: In the `done_o` cycle, `sp_new_o` equals the chosen pointer minus 4. It holds that value until the next save finishes.
- R9: `accept_i` is ignored while a save is in progress, including the `done_o` cycle. Such a pulse does not change the write sequence, and no write follows the `done_o` cycle.
- R10: The pointers, the source information and the context are captured in the cycle where `accept_i` is taken. Later changes to those inputs do not affect the writes or `sp_new_o`.
- R11: After reset, `wr_valid_o` = 0, `done_o` = 0, `sp_new_o` = 0 and `sp_user_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | Interrupt accepted; starts a save when idle |
| swi_i | input | 1 | The accepted interrupt is a software interrupt |
| swi_num_i | input | 6 | Software interrupt number |
| uflag_i | input | 1 | Stack select flag from the flag register |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| flg_i | input | 16 | Flag register to save |
| pc_i | input | 20 | Program counter to save |
| wr_valid_o | output | 1 | Memory write request valid |
| wr_ready_i | input | 1 | Memory accepts the current write |
| wr_addr_o | output | 16 | Byte address of the write |
| wr_data_o | output | 16 | Write data |
| wr_be_o | output | 2 | Byte enables (bit 0 = bits 7:0, bit 1 = bits 15:8) |
| sp_new_o | output | 16 | Stack pointer value after the save |
| sp_user_o | output | 1 | The user stack pointer was used |
| done_o | output | 1 | One-cycle pulse when the save is complete |

## Verification
The bound checker examines every cycle. It confirms that a stalled write holds its payload, that byte lanes match address parity with the unused lane at zero, that 16-bit writes are aligned, that addresses step down by 2 (word) or 1 (byte) between consecutive writes, and that `done_o` is a single pulse that follows a handshake and is never followed by a write. Some properties depend on what was captured at acceptance, and only the bench's reference model can confirm them: the stack choice for numbers on either side of 32 and 63, the byte contents and nibble packing, the final pointer value, and the write count per parity. The same holds for the disturbance scenarios (inputs changed during a save, an accept pulsed during the burst or in the done cycle) under several ready patterns.

// File: rtl/intr_ctx_pkg.sv
package intr_ctx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } push_state_e;

  localparam int unsigned BEATS_EVEN = 2;
  localparam int unsigned BEATS_ODD  = 4;
  localparam int unsigned CTX_BYTES  = 4;
endpackage

// File: rtl/ctx_sp_select.sv
module ctx_sp_select #(
  parameter int unsigned AW      = 16,
  parameter int unsigned NUM_W   = 6,
  parameter int unsigned USER_LO = 32,
  parameter int unsigned USER_HI = 63
) (
  input  logic             swi,
  input  logic [NUM_W-1:0] num,
  input  logic             uflag,
  input  logic [AW-1:0]    isp,
  input  logic [AW-1:0]    usp,
  output logic [AW-1:0]    sp,
  output logic             use_user
);
  logic in_range;

  always_comb begin
    in_range = (32'(num) >= USER_LO) && (32'(num) <= USER_HI);
    use_user = swi && in_range && uflag;
    sp       = use_user ? usp : isp;
  end
endmodule

// File: rtl/ctx_beat_gen.sv
module ctx_beat_gen
  import intr_ctx_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned PC_W  = 20,
  parameter int unsigned FLG_W = 16
) (
  input  logic [AW-1:0]    sp,
  input  logic [PC_W-1:0]  pc,
  input  logic [FLG_W-1:0] flg,
  input  logic             odd,
  input  logic [1:0]       step,
  output logic [AW-1:0]    addr,
  output logic [15:0]      data,
  output logic [1:0]       be,
  output logic             last
);
  localparam int unsigned PCX_W = PC_W - 16;
  localparam int unsigned FGX_W = 8 - PCX_W;

  logic [7:0] img [CTX_BYTES];
  logic [7:0] sel_byte;
  logic [2:0] off;
  logic [1:0] idx;

  // Stack image, index 0 sits at the lowest address (SP-4).
  assign img[0] = pc[7:0];
  assign img[1] = pc[15:8];
  assign img[2] = flg[7:0];
  assign img[3] = {flg[FLG_W-1 -: FGX_W], pc[PC_W-1:16]};

  always_comb begin
    idx      = 2'd3 - step;
    sel_byte = img[idx];
    if (!odd) begin
      off  = (step == 2'd0) ? 3'd2 : 3'd4;
      addr = sp - AW'(off);
      data = (step == 2'd0) ? {img[3], img[2]} : {img[1], img[0]};
      be   = 2'b11;
      last = (step == 2'(BEATS_EVEN - 1));
    end else begin
      off  = 3'(step) + 3'd1;
      addr = sp - AW'(off);
      data = addr[0] ? {sel_byte, 8'h00} : {8'h00, sel_byte};
      be   = addr[0] ? 2'b10 : 2'b01;
      last = (step == 2'(BEATS_ODD - 1));
    end
  end
endmodule

// File: rtl/intr_ctx_push.sv
module intr_ctx_push
  import intr_ctx_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned NUM_W = 6,
  parameter int unsigned PC_W  = 20,
  parameter int unsigned FLG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             swi_i,
  input  logic [NUM_W-1:0] swi_num_i,
  input  logic             uflag_i,
  input  logic [AW-1:0]    isp_i,
  input  logic [AW-1:0]    usp_i,
  input  logic [FLG_W-1:0] flg_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic [AW-1:0]    wr_addr_o,
  output logic [15:0]      wr_data_o,
  output logic [1:0]       wr_be_o,
  output logic [AW-1:0]    sp_new_o,
  output logic             sp_user_o,
  output logic             done_o
);
  push_state_e      state_q;
  logic [1:0]       step_q;
  logic [AW-1:0]    sp_q;
  logic             odd_q;
  logic [PC_W-1:0]  pc_q;
  logic [FLG_W-1:0] flg_q;
  logic [AW-1:0]    sp_new_q;
  logic             user_q;
  logic             user_out_q;

  logic [AW-1:0]    sel_sp;
  logic             sel_user;
  logic             beat_last;

  ctx_sp_select #(.AW(AW), .NUM_W(NUM_W)) u_sel (
    .swi      (swi_i),
    .num      (swi_num_i),
    .uflag    (uflag_i),
    .isp      (isp_i),
    .usp      (usp_i),
    .sp       (sel_sp),
    .use_user (sel_user)
  );

  ctx_beat_gen #(.AW(AW), .PC_W(PC_W), .FLG_W(FLG_W)) u_beat (
    .sp   (sp_q),
    .pc   (pc_q),
    .flg  (flg_q),
    .odd  (odd_q),
    .step (step_q),
    .addr (wr_addr_o),
    .data (wr_data_o),
    .be   (wr_be_o),
    .last (beat_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      sp_q       <= '0;
      odd_q      <= 1'b0;
      pc_q       <= '0;
      flg_q      <= '0;
      sp_new_q   <= '0;
      user_q     <= 1'b0;
      user_out_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_i) begin
          sp_q    <= sel_sp;
          odd_q   <= sel_sp[0];
          user_q  <= sel_user;
          pc_q    <= pc_i;
          flg_q   <= flg_i;
          step_q  <= '0;
          state_q <= ST_BUSY;
        end
        ST_BUSY: if (wr_ready_i) begin
          if (beat_last) begin
            sp_new_q   <= sp_q - AW'(4);
            user_out_q <= user_q;
            state_q    <= ST_DONE;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid_o = (state_q == ST_BUSY);
  assign done_o     = (state_q == ST_DONE);
  assign sp_new_o   = sp_new_q;
  assign sp_user_o  = user_out_q;
endmodule

// File: rtl/intr_ctx_push_chk.sv
module intr_ctx_push_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid_o,
  input logic          wr_ready_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [15:0]   wr_data_o,
  input logic [1:0]    wr_be_o,
  input logic          done_o
);
  a_r6_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o)
                                  && $stable(wr_data_o) && $stable(wr_be_o));

  a_r5_lane_parity: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_be_o != 2'b11 |-> wr_be_o == (wr_addr_o[0] ? 2'b10 : 2'b01));

  a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_be_o == 2'b11 |-> !wr_addr_o[0]);

  a_r5_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_be_o == 2'b01 |-> wr_data_o[15:8] == 8'h00);

  a_r5_idle_lane_zero_hi: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_be_o == 2'b10 |-> wr_data_o[7:0] == 8'h00);

  a_r2_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_be_o == 2'b11 && $past(wr_valid_o && wr_ready_i)
      |-> wr_addr_o == $past(wr_addr_o) - AW'(2));

  a_r3_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && wr_be_o != 2'b11 && $past(wr_valid_o && wr_ready_i)
      |-> wr_addr_o == $past(wr_addr_o) - AW'(1));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_valid_o && $past(wr_valid_o && wr_ready_i));

  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !wr_valid_o);
endmodule

bind intr_ctx_push intr_ctx_push_chk #(.AW(AW)) u_chk (.*);

// File: tb/intr_ctx_push_tb.sv
`timescale 1ns/1ps
module intr_ctx_push_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accept_i = 1'b0;
  logic        swi_i = 1'b0;
  logic [5:0]  swi_num_i = '0;
  logic        uflag_i = 1'b0;
  logic [15:0] isp_i = '0;
  logic [15:0] usp_i = '0;
  logic [15:0] flg_i = '0;
  logic [19:0] pc_i = '0;
  logic        wr_ready_i = 1'b1;
  logic        wr_valid_o;
  logic [15:0] wr_addr_o;
  logic [15:0] wr_data_o;
  logic [1:0]  wr_be_o;
  logic [15:0] sp_new_o;
  logic        sp_user_o;
  logic        done_o;

  intr_ctx_push u_dut (
    .clk(clk), .rst_n(rst_n), .accept_i(accept_i), .swi_i(swi_i),
    .swi_num_i(swi_num_i), .uflag_i(uflag_i), .isp_i(isp_i), .usp_i(usp_i),
    .flg_i(flg_i), .pc_i(pc_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o),
    .sp_new_o(sp_new_o), .sp_user_o(sp_user_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  int    ready_mode = 0;
  bit    finished = 0;
  string scen = "R11 reset";

  // Reference model state
  logic [33:0] mq[$];
  bit          m_done = 0;
  logic [15:0] m_sp = '0;
  bit          m_user = 0;
  logic [15:0] m_sp_new = '0;
  bit          m_user_out = 0;
  int          m_beats = 0;
  int          dut_hs = 0;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", scen, what, act, exp, cyc);
    end
  endtask

  task automatic build(input bit swi, input int num, input bit u,
                       input logic [15:0] isp, input logic [15:0] usp,
                       input logic [15:0] flg, input logic [19:0] pc);
    logic [7:0]  b [4];
    logic [15:0] a;
    bit          uu;
    uu   = swi && num >= 32 && num <= 63 && u;
    m_sp = uu ? usp : isp;
    m_user = uu;
    b[0] = pc[7:0];
    b[1] = pc[15:8];
    b[2] = flg[7:0];
    b[3] = {flg[15:12], pc[19:16]};
    if (!m_sp[0]) begin
      mq.push_back({m_sp - 16'd2, b[3], b[2], 2'b11});
      mq.push_back({m_sp - 16'd4, b[1], b[0], 2'b11});
      m_beats = 2;
    end else begin
      for (int k = 0; k < 4; k++) begin
        a = m_sp - 16'(k + 1);
        mq.push_back({a, a[0] ? {b[3-k], 8'h00} : {8'h00, b[3-k]}, a[0] ? 2'b10 : 2'b01});
      end
      m_beats = 4;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_done = 0; m_sp_new = '0; m_user_out = 0; dut_hs = 0;
    end else begin
      bit was_busy;
      bit was_done;
      was_busy = mq.size() != 0;
      was_done = m_done;
      if (wr_valid_o && wr_ready_i) dut_hs++;
      m_done = 0;
      if (was_busy && wr_ready_i) begin
        void'(mq.pop_front());
        if (mq.size() == 0) begin
          m_done = 1;
          m_sp_new = m_sp - 16'd4;
          m_user_out = m_user;
        end
      end
      if (accept_i && !was_busy && !was_done) begin
        dut_hs = 0;
        build(swi_i, int'(swi_num_i), uflag_i, isp_i, usp_i, flg_i, pc_i);
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (cyc > 0 && !finished) begin
      check("R6 valid", 32'(wr_valid_o), 32'(mq.size() != 0));
      if (mq.size() != 0) begin
        check("R2/R3 address", 32'(wr_addr_o), 32'(mq[0][33:18]));
        check("R4 data", 32'(wr_data_o), 32'(mq[0][17:2]));
        check("R5 byte enables", 32'(wr_be_o), 32'(mq[0][1:0]));
      end
      check("R7 done", 32'(done_o), 32'(m_done));
      check("R8 new pointer", 32'(sp_new_o), 32'(m_sp_new));
      check("R1 user select", 32'(sp_user_o), 32'(m_user_out));
      if (done_o) check("R2/R3 write count", 32'(dut_hs), 32'(m_beats));
    end
  end

  task automatic tick();
    @(negedge clk);
    cyc++;
    case (ready_mode)
      0: wr_ready_i = 1'b1;
      1: wr_ready_i = cyc[0];
      default: wr_ready_i = (cyc % 3 == 0);
    endcase
  endtask

  task automatic save(input bit swi, input int num, input bit u,
                      input logic [15:0] isp, input logic [15:0] usp,
                      input logic [15:0] flg, input logic [19:0] pc,
                      input bit scramble, input bit poke);
    tick();
    swi_i = swi; swi_num_i = 6'(num); uflag_i = u;
    isp_i = isp; usp_i = usp; flg_i = flg; pc_i = pc;
    accept_i = 1'b1;
    tick();
    accept_i = 1'b0;
    if (scramble) begin  // R10: inputs change after capture
      swi_i = ~swi; swi_num_i = ~swi_num_i; uflag_i = ~u;
      isp_i = isp ^ 16'h5a5b; usp_i = usp ^ 16'ha5a5;
      flg_i = ~flg; pc_i = ~pc;
    end
    while (!done_o) begin
      accept_i = poke;  // R9: accept during the burst
      tick();
    end
    accept_i = poke;    // R9: accept in the done cycle
    tick();
    accept_i = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    #100000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    scen = "R11 reset";
    check("R11 valid", 32'(wr_valid_o), 0);
    check("R11 done", 32'(done_o), 0);
    check("R11 sp_new", 32'(sp_new_o), 0);
    check("R11 sp_user", 32'(sp_user_o), 0);
    rst_n = 1'b1;
    tick();

    scen = "R2 even hardware isp";
    save(0, 40, 1, 16'h1000, 16'h2001, 16'hA3C5, 20'h9_1234, 0, 0);
    scen = "R3 odd isp";
    save(0, 0, 0, 16'h0457, 16'h2000, 16'h5E71, 20'h3_ABCD, 0, 0);
    scen = "R1 user swi 32";
    save(1, 32, 1, 16'h1000, 16'h2001, 16'hF00F, 20'hC_0102, 0, 0);
    scen = "R1 user swi 63";
    save(1, 63, 1, 16'h1001, 16'h3FFE, 16'h1234, 20'h5_6789, 0, 0);
    scen = "R1 swi 31 isp";
    save(1, 31, 1, 16'h0A02, 16'h3333, 16'h8001, 20'hF_FFFF, 0, 0);
    scen = "R1 swi 40 uflag clear";
    save(1, 40, 0, 16'h0A03, 16'h4444, 16'h7FFE, 20'h0_0001, 0, 0);
    scen = "R8 wrap at zero";
    save(0, 0, 0, 16'h0002, 16'h0000, 16'hBEEF, 20'hA_5A5A, 0, 0);

    ready_mode = 1;
    scen = "R6 stall even";
    save(1, 50, 1, 16'h0100, 16'h7F00, 16'hC3A1, 20'h2_4680, 0, 0);
    ready_mode = 2;
    scen = "R6 stall odd";
    save(1, 50, 1, 16'h0100, 16'h7F03, 16'h0F0F, 20'hD_1357, 0, 0);

    scen = "R10 scramble odd";
    save(0, 5, 1, 16'h0201, 16'h0300, 16'h9966, 20'h7_2468, 1, 0);
    ready_mode = 1;
    scen = "R9 accept while busy";
    save(1, 33, 1, 16'h0400, 16'h0511, 16'h6699, 20'hB_8642, 1, 1);
    ready_mode = 0;
    scen = "R9 accept while busy even";
    save(0, 1, 0, 16'h0602, 16'h0700, 16'h1111, 20'h1_1111, 0, 1);
    scen = "R5 odd after even";
    save(1, 60, 1, 16'h0000, 16'hFFFF, 16'h2222, 20'hE_EEEE, 0, 0);

    tick(); tick();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule